// File: doc/BRIEF.md
# Serial EEPROM Random-Access Sequencer

This block turns a single user request into the complete chain of bus commands needed to write or read one byte of a small 256-byte two-wire serial EEPROM. It sits above a byte-level bus engine that understands four one-hot commands: bus start condition, write one byte, read one byte, and bus stop condition. The engine holds all bus timing, so the sequencer only orders commands and supplies bytes. It also watches the acknowledge level that the engine samples during every byte.

A user asserts `reqValid` with a direction, a word address and write data. The sequencer presents each command for one clock. It then waits for the engine's busy line to rise and fall, checks the acknowledge after each byte it wrote, and moves to the next step. Each transaction ends with a stop. The user then sees a one-cycle `doneValid` pulse, with read data and an error flag. The master never acknowledges a byte it reads, so a read always fetches exactly one byte.

Top module: `eeprom_seq`

## Requirements
- R1: `busCmd` is 4'b0000 except for single-cycle command strobes, each with exactly one bit set: start condition = 4'b1000, write byte = 4'b0100, read byte = 4'b0010, stop condition = 4'b0001.
- R2: A command is presented only while `busBusy` is low, and the next command follows only after `busBusy` has risen and then fallen for the previous one.
- R3: A write transaction issues, in order: start, write 0xA0, write word address, write data byte, stop. The byte for each write-byte strobe is on `busTxByte` in the same cycle.
- R4: A read transaction issues, in order: start, write 0xA0, write word address, start, write 0xA1, read, stop.
- R5: The device address byte is the 7-bit device identifier 7'b1010000 in bits 7:1, followed by the direction bit in bit 0 (0 = write, 1 = read).
- R6: If `busAck` is high when a write-byte command completes, no further bytes are sent. The next command is stop, and `doneValid` then pulses with `errFlag` = 1.
- R7: On a read that is acknowledged throughout, `rdData` equals the `busRxByte` value present when the read command completed, and it is valid with the done pulse. `errFlag` = 0 on any transaction that is acknowledged throughout.
- R8: `doneValid` is a single-cycle pulse that follows completion of the stop command.
- R9: A `reqValid` that arrives while a transaction is in progress is ignored. The running transaction keeps its own address, data and direction.
- R10: While reset is asserted, and after it is released, `busCmd` is 4'b0000, `doneValid` is 0 and `errFlag` is 0 until a request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| reqValid | input | 1 | Start a transaction (sampled in idle only) |
| reqRead | input | 1 | 1 = random read, 0 = random write |
| reqAddr | input | 8 | EEPROM word address |
| reqWdata | input | 8 | Byte to write |
| doneValid | output | 1 | One-cycle completion pulse |
| rdData | output | 8 | Byte returned by a read |
| errFlag | output | 1 | Transaction ended on a missing acknowledge |
| busCmd | output | 4 | One-hot command to the bus engine |
| busTxByte | output | 8 | Byte for a write-byte command |
| busBusy | input | 1 | Engine is executing a command |
| busAck | input | 1 | Sampled acknowledge level, high = not acknowledged |
| busRxByte | input | 8 | Byte received by a read command |

## Verification
The assertions assume the engine raises `busBusy` only in response to a command. Once it is low it stays low until the next strobe, and `busAck` stays stable from the command until busy falls. The bench's engine model keeps to this: it raises busy on the edge after each strobe for a random one to four cycles, and it sets the acknowledge and receive byte at that same edge. Stray requests are injected only in the middle of a transaction, never at its done cycle, so the ignore rule is tested without a race against acceptance.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;
  localparam logic [3:0] CMD_NONE  = 4'b0000;
  localparam logic [3:0] CMD_START = 4'b1000;
  localparam logic [3:0] CMD_WRITE = 4'b0100;
  localparam logic [3:0] CMD_READ  = 4'b0010;
  localparam logic [3:0] CMD_STOP  = 4'b0001;

  typedef enum logic [1:0] {TX_DEV, TX_ADDR, TX_DATA} txSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   capture;
    logic   setErr;
    logic   latchRd;
    logic   devRead;
    txSel_e txSel;
  } dpCtl_t;
endpackage

// File: rtl/eeprom_seq_ctrl.sv
module eeprom_seq_ctrl
  import eeprom_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqRead,
  input  logic       busBusy,
  input  logic       busAck,
  output logic [3:0] busCmd,
  output logic       doneValid,
  output dpCtl_t     dpCtl
);
  typedef enum logic [2:0] {PH_IDLE, PH_ISSUE, PH_WAITHI, PH_WAITLO, PH_DONE} phase_e;
  typedef enum logic [2:0] {
    ST_START, ST_DEVW, ST_ADDR, ST_DATA, ST_RESTART, ST_DEVR, ST_READ, ST_STOP
  } step_e;

  phase_e phaseQ;
  step_e  stepQ;
  logic   isReadQ;

  function automatic step_e nextStep(step_e s, logic rd);
    case (s)
      ST_START:   return ST_DEVW;
      ST_DEVW:    return ST_ADDR;
      ST_ADDR:    return rd ? ST_RESTART : ST_DATA;
      ST_RESTART: return ST_DEVR;
      ST_DEVR:    return ST_READ;
      default:    return ST_STOP;
    endcase
  endfunction

  function automatic logic [3:0] cmdOf(step_e s);
    case (s)
      ST_START, ST_RESTART:          return CMD_START;
      ST_READ:                       return CMD_READ;
      ST_STOP:                       return CMD_STOP;
      default:                       return CMD_WRITE;
    endcase
  endfunction

  logic isWriteStep;
  logic stepDone;
  assign isWriteStep = (cmdOf(stepQ) == CMD_WRITE);
  assign stepDone    = (phaseQ == PH_WAITLO) && !busBusy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ  <= PH_IDLE;
      stepQ   <= ST_START;
      isReadQ <= 1'b0;
    end else begin
      case (phaseQ)
        PH_IDLE: if (reqValid) begin
          phaseQ  <= PH_ISSUE;
          stepQ   <= ST_START;
          isReadQ <= reqRead;
        end
        PH_ISSUE:  phaseQ <= PH_WAITHI;
        PH_WAITHI: if (busBusy) phaseQ <= PH_WAITLO;
        PH_WAITLO: if (!busBusy) begin
          if (stepQ == ST_STOP) begin
            phaseQ <= PH_DONE;
          end else if (isWriteStep && busAck) begin
            stepQ  <= ST_STOP;
            phaseQ <= PH_ISSUE;
          end else begin
            stepQ  <= nextStep(stepQ, isReadQ);
            phaseQ <= PH_ISSUE;
          end
        end
        default: phaseQ <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    busCmd          = (phaseQ == PH_ISSUE) ? cmdOf(stepQ) : CMD_NONE;
    doneValid       = (phaseQ == PH_DONE);
    dpCtl.capture   = (phaseQ == PH_IDLE) && reqValid;
    dpCtl.setErr    = stepDone && isWriteStep && busAck;
    dpCtl.latchRd   = stepDone && (stepQ == ST_READ);
    dpCtl.devRead   = (stepQ == ST_DEVR);
    case (stepQ)
      ST_DEVW, ST_DEVR: dpCtl.txSel = TX_DEV;
      ST_ADDR:          dpCtl.txSel = TX_ADDR;
      default:          dpCtl.txSel = TX_DATA;
    endcase
  end

  // R1: one-hot strobes lasting one cycle
  assert_cmd_onehot_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(busCmd));
  assert_cmd_single_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busCmd != CMD_NONE) |=> (busCmd == CMD_NONE));
  // R2: never issue onto a busy engine
  assert_cmd_idle_engine_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busCmd != CMD_NONE) |-> !busBusy);
  // R8: done is a pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);
  // R8: done comes right after a completed stop, no command with it
  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (busCmd == CMD_NONE) && $past(stepQ == ST_STOP));
endmodule

// File: rtl/eeprom_seq_dp.sv
module eeprom_seq_dp
  import eeprom_seq_pkg::*;
#(
  parameter int        DATA_W = 8,
  parameter int        ADDR_W = 8,
  parameter logic [6:0] DEV_ID = 7'b1010000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busRxByte,
  output logic [DATA_W-1:0] busTxByte,
  output logic [DATA_W-1:0] rdData,
  output logic              errFlag
);
  localparam int PAD_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      wdataQ  <= '0;
      rdData  <= '0;
      errFlag <= 1'b0;
    end else begin
      if (dpCtl.capture) begin
        addrQ   <= reqAddr;
        wdataQ  <= reqWdata;
        errFlag <= 1'b0;
      end
      if (dpCtl.setErr)  errFlag <= 1'b1;
      if (dpCtl.latchRd) rdData  <= busRxByte;
    end
  end

  logic [DATA_W-1:0] addrByte;
  generate
    if (PAD_W > 0) begin : g_pad
      assign addrByte = {{PAD_W{1'b0}}, addrQ};
    end else begin : g_nopad
      assign addrByte = addrQ[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    case (dpCtl.txSel)
      TX_DEV:  busTxByte = {{(DATA_W-8){1'b0}}, DEV_ID, dpCtl.devRead};
      TX_ADDR: busTxByte = addrByte;
      default: busTxByte = wdataQ;
    endcase
  end

  // R6: an error can only be raised by a sample on a completed write
  assert_err_only_on_nack_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> $past(dpCtl.setErr));
endmodule

// File: rtl/eeprom_seq.sv
module eeprom_seq
  import eeprom_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqRead,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              doneValid,
  output logic [DATA_W-1:0] rdData,
  output logic              errFlag,
  output logic [3:0]        busCmd,
  output logic [DATA_W-1:0] busTxByte,
  input  logic              busBusy,
  input  logic              busAck,
  input  logic [DATA_W-1:0] busRxByte
);
  dpCtl_t dpCtl;

  eeprom_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRead(reqRead),
    .busBusy(busBusy), .busAck(busAck), .busCmd(busCmd),
    .doneValid(doneValid), .dpCtl(dpCtl)
  );

  eeprom_seq_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .busRxByte(busRxByte), .busTxByte(busTxByte),
    .rdData(rdData), .errFlag(errFlag)
  );
endmodule

// File: tb/eeprom_seq_bench.sv
module eeprom_seq_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0, reqRead = 1'b0;
  logic [7:0] reqAddr = '0, reqWdata = '0;
  logic       doneValid, errFlag;
  logic [7:0] rdData, busTxByte;
  logic [3:0] busCmd;
  logic       busBusy = 1'b0, busAck = 1'b0;
  logic [7:0] busRxByte = '0;

  always #2.5 clk = ~clk;

  eeprom_seq u_eeprom_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRead(reqRead),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .doneValid(doneValid),
    .rdData(rdData), .errFlag(errFlag), .busCmd(busCmd),
    .busTxByte(busTxByte), .busBusy(busBusy), .busAck(busAck),
    .busRxByte(busRxByte)
  );

  int total = 0, bad = 0, cycles = 0;
  bit finished = 0;

  // engine model
  logic [3:0] logCmd [64];
  logic [7:0] logByte [64];
  int logN = 0, wrIdx = 0, busyCnt = 0;
  int nackAbs = -1;
  logic [7:0] rxVal = 8'h00;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rstN) begin
      busBusy <= 1'b0;
    end else if (busCmd != 4'b0000) begin
      logCmd[logN % 64]  <= busCmd;
      logByte[logN % 64] <= busTxByte;
      logN    <= logN + 1;
      busBusy <= 1'b1;
      busyCnt <= 1 + int'($urandom % 4);
      if (busCmd == 4'b0100) begin
        busAck <= (wrIdx == nackAbs);
        wrIdx  <= wrIdx + 1;
      end
      if (busCmd == 4'b0010) busRxByte <= rxVal;
    end else if (busBusy) begin
      if (busyCnt <= 1) busBusy <= 1'b0;
      else busyCnt <= busyCnt - 1;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  logic [3:0] expCmd [8];
  logic [7:0] expByte [8];
  int expLen;

  task automatic push(logic [3:0] c, logic [7:0] b);
    expCmd[expLen] = c; expByte[expLen] = b; expLen++;
  endtask

  // nk: index of the write byte that is not acknowledged, -1 for none
  task automatic buildExp(bit rd, logic [7:0] a, logic [7:0] d, int nk);
    int w = 0;
    expLen = 0;
    push(4'b1000, 8'h00);
    push(4'b0100, 8'hA0);
    if (nk == w) begin push(4'b0001, 0); return; end
    w++;
    push(4'b0100, a);
    if (nk == w) begin push(4'b0001, 0); return; end
    w++;
    if (!rd) begin
      push(4'b0100, d);
      push(4'b0001, 0);
      return;
    end
    push(4'b1000, 8'h00);
    push(4'b0100, 8'hA1);
    if (nk == w) begin push(4'b0001, 0); return; end
    push(4'b0010, 8'h00);
    push(4'b0001, 8'h00);
  endtask

  task automatic runTxn(bit rd, logic [7:0] a, logic [7:0] d, int nk,
                        logic [7:0] rx, bit stray);
    int base;
    int waitN = 0;
    bit seen = 0;
    buildExp(rd, a, d, nk);
    rxVal = rx;
    nackAbs = (nk < 0) ? -1 : wrIdx + nk;
    base = logN;
    @(negedge clk);
    reqValid = 1; reqRead = rd; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 0;
    while (!seen && waitN < 500) begin
      @(negedge clk);
      waitN++;
      if (stray && waitN == 6) begin
        reqValid = 1; reqRead = ~rd; reqAddr = ~a; reqWdata = ~d;
      end else reqValid = 0;
      if (doneValid) seen = 1;
    end
    reqValid = 0;
    check(seen, "R8", "done seen", seen, 1);
    check(errFlag == (nk >= 0), "R6", "errFlag", errFlag, (nk >= 0));
    if (rd && nk < 0) check(rdData == rx, "R7", "rdData", rdData, rx);
    @(negedge clk);
    check(!doneValid, "R8", "done width", doneValid, 0);
    check(busCmd == 0, "R1", "cmd idle after done", busCmd, 0);
    check(logN - base == expLen, rd ? "R4" : "R3", "cmd count", logN - base, expLen);
    for (int i = 0; i < expLen && i < logN - base; i++) begin
      check(logCmd[(base + i) % 64] == expCmd[i], stray ? "R9" : (rd ? "R4" : "R3"),
            "cmd", logCmd[(base + i) % 64], expCmd[i]);
      if (expCmd[i] == 4'b0100)
        check(logByte[(base + i) % 64] == expByte[i], (i == 1 || i == 4) ? "R5" : "R3",
              "byte", logByte[(base + i) % 64], expByte[i]);
    end
  endtask

  initial begin : watchdog
    wait (cycles > 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = int'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(busCmd == 0, "R10", "cmd in reset", busCmd, 0);
    check(!doneValid, "R10", "done in reset", doneValid, 0);
    rstN = 1;
    repeat (2) @(negedge clk);
    check(busCmd == 0 && !errFlag, "R10", "idle after reset", {errFlag, busCmd}, 0);
    check(!busBusy, "R2", "engine idle", busBusy, 0);
    // directed corners
    runTxn(0, 8'h00, 8'h5A, -1, 8'h00, 0);
    runTxn(1, 8'hFF, 8'h00, -1, 8'hC3, 0);
    runTxn(0, 8'h10, 8'h11, 0, 8'h00, 0);
    runTxn(0, 8'h20, 8'h22, 1, 8'h00, 0);
    runTxn(0, 8'h30, 8'h33, 2, 8'h00, 0);
    runTxn(1, 8'h40, 8'h00, 1, 8'h99, 0);
    runTxn(1, 8'h50, 8'h00, 2, 8'h77, 0);
    runTxn(0, 8'h7E, 8'hE7, -1, 8'h00, 1);
    runTxn(1, 8'h81, 8'h00, -1, 8'h3C, 1);
    runTxn(0, 8'h01, 8'h02, -1, 8'h00, 0);   // R6: error clears on next clean run
    // random
    for (int n = 0; n < 60; n++) begin
      bit rd = 1'($urandom);
      int nk = (($urandom % 4) == 0) ? int'($urandom % 3) : -1;
      runTxn(rd, 8'($urandom), 8'($urandom), nk, 8'($urandom), (($urandom % 3) == 0));
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule